// File: doc/BRIEF.md
# Memory Protection Key Checker

This block sits after address translation and decides whether a memory access may proceed. Each request brings the protection-key field taken from the page table entry, the kind of access (data load, data store or instruction fetch) and the page's ordinary read, write and execute permission bits. One cycle later the block returns a registered verdict: an allow flag and a cause code. The cause code keeps a page-permission fault apart from a key fault.

The block holds a per-thread rights register with two disable bits for each key. Software reads and writes this register through a special-register port at register number 13. A parameter sets the width of the key field, which gives either 16 or 32 keys. With 16 keys, each bit pair is an access-disable bit and a write-disable bit, and key rights apply to data accesses only. With 32 keys, each pair is a read-disable bit and a write-disable bit. In that mode the block also keeps one execute-disable bit per key, and only a separate privileged port can write it.

Top module: `pkey_gate`

## Requirements
- R1: `KEY_BITS` sets the key width: 4 gives 16 keys and 5 gives 32 keys. The rights register is 2×keys bits wide. For key k, bit 2k is the access-disable bit (16 keys) or the read-disable bit (32 keys), and bit 2k+1 is the write-disable bit.
- R2: After reset the rights register and all execute-disable bits are zero, and `rsp_valid` is low. Every access the page permits is then allowed.
- R3: A write on the special-register port with `spr_num` = 13 loads `spr_wdata` into the rights register. When `spr_rd` is high and `spr_num` = 13, `spr_rdata` shows the register in the same cycle; otherwise `spr_rdata` is zero. Writes to any other number leave the register unchanged.
- R4: With 32 keys, a load faults with the key cause when the key's read-disable bit is set. A store faults with the key cause when the key's write-disable bit is set. Setting both bits blocks both loads and stores.
- R5: With 16 keys, a load faults with the key cause when the key's access-disable bit is set. A store faults with the key cause when either the access-disable bit or the write-disable bit is set.
- R6: With 16 keys, an instruction fetch never raises the key cause, whatever the rights register holds. Writes on the privileged execute-disable port have no effect.
- R7: With 32 keys, a fetch faults with the key cause when the execute-disable bit of its key is set. The rights register has no effect on fetches.
- R8: Execute-disable bits change only through the privileged port (`xd_wr`, `xd_key`, `xd_val`). No special-register write alters them.
- R9: A load needs `pg_read`, a store needs `pg_write` and a fetch needs `pg_exec`; a missing permission gives the permission cause. When the page check and the key check both fail, the permission cause is reported.
- R10: `req_kind` is encoded 00 = load, 01 = store, 1x = fetch. `rsp_cause` is encoded 0 = none, 1 = permission, 2 = key. The verdict for a request with `req_valid` high appears on the next clock with `rsp_valid` high, and `rsp_allow` is high exactly when the cause is none. In cycles with no response, `rsp_allow` and `rsp_cause` are zero.
- R11: A write to the rights register or to an execute-disable bit applies to requests from the following cycle on. A request in the same cycle as the write is checked against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 00 load, 01 store, 1x fetch |
| req_key | input | KEY_BITS | Key field from the page table entry |
| pg_read | input | 1 | Page permits reads |
| pg_write | input | 1 | Page permits writes |
| pg_exec | input | 1 | Page permits execution |
| spr_wr | input | 1 | Special-register write strobe |
| spr_rd | input | 1 | Special-register read strobe |
| spr_num | input | 10 | Special-register number |
| spr_wdata | input | 2*2^KEY_BITS | Special-register write data |
| spr_rdata | output | 2*2^KEY_BITS | Rights register read data |
| xd_wr | input | 1 | Privileged execute-disable write strobe |
| xd_key | input | KEY_BITS | Key whose execute-disable bit is written |
| xd_val | input | 1 | New execute-disable value |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | Access allowed |
| rsp_cause | output | 2 | 0 none, 1 permission, 2 key |

## Verification
A corrupted rights bit or execute-disable bit can stay hidden for a long time. It shows only on the first access that uses that key with the matching access kind, as a wrong allow flag or cause one cycle after the request. A corrupted rights bit also shows at once on a read at number 13. The bench runs one instance for each key width. It checks the verdict on every clock against a behavioural model, so a stale or wrong value is reported within one cycle of the access that exposes it. Random traffic mixes register writes with requests in the same cycle, which exercises the timing of when a write takes effect.

// File: rtl/pkey_gate.sv
module pkey_gate #(
  parameter int KEY_BITS   = 5,
  parameter int SPR_W      = 10,
  parameter int RIGHTS_SPR = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [1:0]                   req_kind,
  input  logic [KEY_BITS-1:0]          req_key,
  input  logic                         pg_read,
  input  logic                         pg_write,
  input  logic                         pg_exec,
  input  logic                         spr_wr,
  input  logic                         spr_rd,
  input  logic [SPR_W-1:0]             spr_num,
  input  logic [2*(1<<KEY_BITS)-1:0]   spr_wdata,
  output logic [2*(1<<KEY_BITS)-1:0]   spr_rdata,
  input  logic                         xd_wr,
  input  logic [KEY_BITS-1:0]          xd_key,
  input  logic                         xd_val,
  output logic                         rsp_valid,
  output logic                         rsp_allow,
  output logic [1:0]                   rsp_cause
);
  localparam int NKEYS = 1 << KEY_BITS;
  localparam int RW    = 2 * NKEYS;
  localparam bit WIDE  = (KEY_BITS >= 5);
  localparam logic [1:0] C_NONE = 2'd0, C_PERM = 2'd1, C_KEY = 2'd2;

  logic [RW-1:0] rights_q;
  logic          spr_hit;
  logic          dis_lo, dis_wr, xd_hit;
  logic          is_fetch, is_store;
  logic          perm_bad, key_bad;
  logic [1:0]    cause_d;

  assign spr_hit   = (spr_num == SPR_W'(RIGHTS_SPR));
  assign spr_rdata = (spr_rd && spr_hit) ? rights_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                rights_q <= '0;
    else if (spr_wr && spr_hit) rights_q <= spr_wdata;
  end

  generate
    if (WIDE) begin : g_xd
      logic [NKEYS-1:0] xd_q;
      always_ff @(posedge clk) begin
        if (!rst_n)     xd_q <= '0;
        else if (xd_wr) xd_q[xd_key] <= xd_val;
      end
      assign xd_hit = xd_q[req_key];
    end else begin : g_no_xd
      logic unused_xd;
      assign unused_xd = ^{xd_wr, xd_key, xd_val};
      assign xd_hit    = 1'b0;
    end
  endgenerate

  assign dis_lo   = rights_q[{req_key, 1'b0}];
  assign dis_wr   = rights_q[{req_key, 1'b1}];
  assign is_fetch = req_kind[1];
  assign is_store = (req_kind == 2'b01);

  assign perm_bad = is_fetch ? !pg_exec : (is_store ? !pg_write : !pg_read);

  generate
    if (WIDE) begin : g_key32
      assign key_bad = is_fetch ? xd_hit : (is_store ? dis_wr : dis_lo);
    end else begin : g_key16
      assign key_bad = is_fetch ? 1'b0 : (is_store ? (dis_lo | dis_wr) : dis_lo);
    end
  endgenerate

  assign cause_d = perm_bad ? C_PERM : (key_bad ? C_KEY : C_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_cause <= C_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && (cause_d == C_NONE);
      rsp_cause <= req_valid ? cause_d : C_NONE;
    end
  end
endmodule

module pkey_gate_chk #(
  parameter int KEY_BITS   = 5,
  parameter int SPR_W      = 10,
  parameter int RIGHTS_SPR = 13
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [1:0]                 req_kind,
  input logic [KEY_BITS-1:0]        req_key,
  input logic                       pg_read,
  input logic                       pg_write,
  input logic                       pg_exec,
  input logic                       spr_wr,
  input logic                       spr_rd,
  input logic [SPR_W-1:0]           spr_num,
  input logic [2*(1<<KEY_BITS)-1:0] spr_wdata,
  input logic [2*(1<<KEY_BITS)-1:0] spr_rdata,
  input logic                       xd_wr,
  input logic [KEY_BITS-1:0]        xd_key,
  input logic                       xd_val,
  input logic                       rsp_valid,
  input logic                       rsp_allow,
  input logic [1:0]                 rsp_cause
);
  assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_allow && rsp_cause == 2'd0));
  assert_cause_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cause != 2'd3));
  assert_perm_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b00 && !pg_read) |=> (rsp_cause == 2'd1 && !rsp_allow));
  assert_other_spr_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_rd && spr_num != SPR_W'(RIGHTS_SPR)) |-> (spr_rdata == '0));

  generate
    if (KEY_BITS < 5) begin : g_narrow
      assert_fetch_ignores_rights_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[1] && pg_exec) |=> rsp_allow);
    end
  endgenerate
endmodule

bind pkey_gate pkey_gate_chk #(.KEY_BITS(KEY_BITS), .SPR_W(SPR_W), .RIGHTS_SPR(RIGHTS_SPR)) u_chk (.*);

// File: tb/tb_pkey_gate.sv
`timescale 1ns/1ps
module tb_pkey_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0;
  logic [1:0]  req_kind = 0;
  logic [4:0]  req_key = 0;
  logic        pg_read = 0, pg_write = 0, pg_exec = 0;
  logic        spr_wr = 0, spr_rd = 0;
  logic [9:0]  spr_num = 0;
  logic [63:0] spr_wdata = 0;
  logic        xd_wr = 0, xd_val = 0;
  logic [4:0]  xd_key = 0;

  logic [63:0] rd32;
  logic [31:0] rd16;
  logic        v32, a32, v16, a16;
  logic [1:0]  c32, c16;

  pkey_gate #(.KEY_BITS(5)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_key(req_key),
    .pg_read(pg_read), .pg_write(pg_write), .pg_exec(pg_exec),
    .spr_wr(spr_wr), .spr_rd(spr_rd), .spr_num(spr_num), .spr_wdata(spr_wdata), .spr_rdata(rd32),
    .xd_wr(xd_wr), .xd_key(xd_key), .xd_val(xd_val),
    .rsp_valid(v32), .rsp_allow(a32), .rsp_cause(c32));

  pkey_gate #(.KEY_BITS(4)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_key(req_key[3:0]),
    .pg_read(pg_read), .pg_write(pg_write), .pg_exec(pg_exec),
    .spr_wr(spr_wr), .spr_rd(spr_rd), .spr_num(spr_num), .spr_wdata(spr_wdata[31:0]), .spr_rdata(rd16),
    .xd_wr(xd_wr), .xd_key(xd_key[3:0]), .xd_val(xd_val),
    .rsp_valid(v16), .rsp_allow(a16), .rsp_cause(c16));

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R2";

  logic [63:0] m_r32;
  logic [31:0] m_r16;
  logic [31:0] m_xd;
  logic        e_v;
  int          e_c32, e_c16;

  function automatic int ref_cause(bit wide, logic [1:0] kind, int key, bit r, bit w, bit x,
                                   logic [63:0] rights, logic [31:0] xd);
    bit fetch = kind[1];
    bit store = (kind == 2'b01);
    bit lo = rights[2*key];
    bit wd = rights[2*key+1];
    bit kbad;
    if (fetch ? !x : (store ? !w : !r)) return 1;
    if (wide) kbad = fetch ? xd[key] : (store ? wd : lo);
    else      kbad = fetch ? 1'b0 : (store ? (lo | wd) : lo);
    return kbad ? 2 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r32 = '0; m_r16 = '0; m_xd = '0;
      e_v = 0; e_c32 = 0; e_c16 = 0;
    end else begin
      e_v   = req_valid;
      e_c32 = req_valid ? ref_cause(1, req_kind, int'(req_key), pg_read, pg_write, pg_exec, m_r32, m_xd) : 0;
      e_c16 = req_valid ? ref_cause(0, req_kind, int'(req_key[3:0]), pg_read, pg_write, pg_exec,
                                    {32'h0, m_r16}, 32'h0) : 0;
      if (spr_wr && spr_num == 10'd13) begin
        m_r32 = spr_wdata;
        m_r16 = spr_wdata[31:0];
      end
      if (xd_wr) m_xd[xd_key] = xd_val;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (v32 !== e_v || a32 !== (e_v && e_c32 == 0) || c32 !== 2'(e_c32)) begin
        errors++;
        $display("FAIL %s wide: v/a/c=%0b/%0b/%0d expected %0b/%0b/%0d", tag, v32, a32, c32,
                 e_v, e_v && e_c32 == 0, e_c32);
      end
      vectors++;
      if (v16 !== e_v || a16 !== (e_v && e_c16 == 0) || c16 !== 2'(e_c16)) begin
        errors++;
        $display("FAIL %s narrow: v/a/c=%0b/%0b/%0d expected %0b/%0b/%0d", tag, v16, a16, c16,
                 e_v, e_v && e_c16 == 0, e_c16);
      end
    end
  end

  task automatic idle();
    req_valid = 0; spr_wr = 0; spr_rd = 0; xd_wr = 0;
  endtask

  task automatic access(logic [1:0] kind, logic [4:0] key, bit r, bit w, bit x);
    @(negedge clk);
    idle();
    req_valid = 1; req_kind = kind; req_key = key;
    pg_read = r; pg_write = w; pg_exec = x;
  endtask

  task automatic spr_write(logic [9:0] num, logic [63:0] d);
    @(negedge clk);
    idle();
    spr_wr = 1; spr_num = num; spr_wdata = d;
  endtask

  task automatic xd_write(logic [4:0] key, bit v);
    @(negedge clk);
    idle();
    xd_wr = 1; xd_key = key; xd_val = v;
  endtask

  task automatic spr_read(logic [9:0] num);
    logic [63:0] e32;
    logic [31:0] e16;
    @(negedge clk);
    idle();
    spr_rd = 1; spr_num = num;
    #1;
    e32 = (num == 10'd13) ? m_r32 : 64'h0;
    e16 = (num == 10'd13) ? m_r16 : 32'h0;
    vectors++;
    if (rd32 !== e32 || rd16 !== e16) begin
      errors++;
      $display("FAIL R3 read %0d: %h/%h expected %h/%h", num, rd32, rd16, e32, e16);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end

  initial begin
    tag = "R2";
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 3; k++) access(2'(k), 5'(k * 7), 1, 1, 1);
    tag = "R3";
    spr_read(10'd13);
    spr_write(10'd13, 64'hA5A5_0F0F_3C3C_9669);
    spr_read(10'd13);
    spr_write(10'd12, 64'hFFFF_FFFF_FFFF_FFFF);
    spr_read(10'd13);
    spr_read(10'd12);
    tag = "R4 R5 R1";
    spr_write(10'd13, (64'h1 << 6) | (64'h1 << 11) | (64'h3 << 14) | (64'h1 << 41));
    for (int k = 0; k < 8; k++) begin
      access(2'b00, 5'(k), 1, 1, 1);
      access(2'b01, 5'(k), 1, 1, 1);
    end
    access(2'b00, 5'd20, 1, 1, 1);
    access(2'b01, 5'd20, 1, 1, 1);
    tag = "R6 R7";
    access(2'b10, 5'd3, 1, 1, 1);
    access(2'b11, 5'd7, 1, 1, 1);
    xd_write(5'd9, 1);
    access(2'b10, 5'd9, 1, 1, 1);
    access(2'b10, 5'd25, 1, 1, 1);
    tag = "R8";
    spr_write(10'd13, 64'hFFFF_FFFF_FFFF_FFFF);
    access(2'b10, 5'd2, 0, 0, 1);
    access(2'b10, 5'd9, 0, 0, 1);
    tag = "R9";
    access(2'b00, 5'd7, 0, 1, 1);
    access(2'b01, 5'd7, 1, 0, 1);
    access(2'b10, 5'd9, 1, 1, 0);
    tag = "R11";
    @(negedge clk);
    idle();
    spr_wr = 1; spr_num = 10'd13; spr_wdata = 64'h0;
    req_valid = 1; req_kind = 2'b00; req_key = 5'd4; pg_read = 1;
    access(2'b00, 5'd4, 1, 1, 1);
    @(negedge clk);
    idle();
    xd_wr = 1; xd_key = 5'd9; xd_val = 0;
    req_valid = 1; req_kind = 2'b10; req_key = 5'd9; pg_exec = 1;
    access(2'b10, 5'd9, 1, 1, 1);
    tag = "R10 random";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      req_valid = $urandom_range(0, 3) != 0;
      req_kind  = 2'($urandom);
      req_key   = 5'($urandom);
      pg_read   = $urandom_range(0, 3) != 0;
      pg_write  = $urandom_range(0, 3) != 0;
      pg_exec   = $urandom_range(0, 3) != 0;
      spr_wr    = $urandom_range(0, 7) == 0;
      spr_num   = ($urandom_range(0, 3) == 0) ? 10'd12 : 10'd13;
      spr_wdata = {32'($urandom), 32'($urandom)};
      spr_rd    = 0;
      xd_wr     = $urandom_range(0, 5) == 0;
      xd_key    = 5'($urandom);
      xd_val    = 1'($urandom);
    end
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule